// File: doc/BRIEF.md
# Next-PC and Branch/Jump Unit

This block owns the program counter of a processor whose instructions are all 32 bits wide. Each cycle it looks at the instruction word under the current PC and at the value read from that instruction's source register. From these it picks the address of the next instruction. The choices are:

- the sequential address PC+4;
- a PC-relative target with a 26-bit displacement (jump);
- a PC-relative target with a 16-bit displacement (branch on zero or nonzero);
- the register value itself (register-indirect jump).

For the linking jumps it also hands PC+4 to the register file as the return address for register 31.

The PC is held in a register inside the block. It resets to zero and moves to the computed next address on every clock edge where the step enable is high. The displacements are byte offsets added to PC+4 without scaling. All address arithmetic wraps modulo 2^32.

Opcodes that the block does not recognise fall through to PC+4 and raise an illegal-instruction flag. A dedicated trap opcode raises a trap request and leaves the exception handling to the surrounding core.

Top module: `npc_unit`

## Requirements
- R1: After reset `pcOut` is 0. On a rising clock edge with `stepEn` high, `pcOut` takes the value `nextPc` had before the edge. With `stepEn` low it holds.
- R2: Opcodes (bits 31..26) 0x00, 0x08 to 0x0F and 0x20 to 0x2F are ordinary instructions. For them `nextPc` is `pcOut`+4, and `linkWe`, `illegal` and `trapReq` are all 0.
- R3: Opcode 0x02 (jump) gives `nextPc` = `pcOut`+4 + the sign-extended bits 25..0, with no link write.
- R4: Opcode 0x03 (jump-and-link) gives the same target as R3. It also raises `linkWe` and drives `linkData` = `pcOut`+4, the return address for register 31.
- R5: Opcode 0x04 (branch if zero) gives `pcOut`+4 + the sign-extended bits 15..0 when `srcVal` is 0, and `pcOut`+4 otherwise.
- R6: Opcode 0x05 (branch if nonzero) gives `pcOut`+4 + the sign-extended bits 15..0 when `srcVal` is not 0, and `pcOut`+4 otherwise.
- R7: Opcode 0x12 (register jump) gives `nextPc` = `srcVal`, with no link write.
- R8: Opcode 0x13 (register jump-and-link) gives `nextPc` = `srcVal`, raises `linkWe` and drives `linkData` = `pcOut`+4.
- R9: Opcode 0x11 (trap) raises `trapReq` and gives `nextPc` = `pcOut`+4, with no link write.
- R10: Any other opcode raises `illegal` and gives `nextPc` = `pcOut`+4, with no link write.
- R11: `linkWe` is 0 whenever `stepEn` is low, even for a linking jump.
- R12: Target arithmetic wraps modulo 2^32. The most negative displacements (0x2000000 for a jump, 0x8000 for a branch) reach back by exactly 2^25 and 2^15 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | Advance the PC this cycle |
| instr | input | 32 | Instruction word at the current PC |
| srcVal | input | 32 | Value of the instruction's source register |
| pcOut | output | 32 | Current program counter |
| nextPc | output | 32 | Address of the next instruction |
| linkWe | output | 1 | Write return address into register 31 |
| linkData | output | 32 | Return address (current PC + 4) |
| illegal | output | 1 | Opcode not recognised |
| trapReq | output | 1 | Trap opcode seen |

## Verification
A corrupted PC register shows at `pcOut` and in every target from the next edge on. Because each later target is relative to it, one wrong step shifts all following table rows, so the fault is caught within one instruction.

A mis-decoded opcode or an inverted zero test is visible on `nextPc` and on the flag outputs in the same cycle, before the PC is updated. A wrong sign extension only appears with negative displacements, so the vectors include backward jumps and branches and the most negative offsets.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int OP_W = 6;

  // Opcode values the control recognises
  localparam logic [OP_W-1:0] OP_JMP   = 6'h02;
  localparam logic [OP_W-1:0] OP_JMPL  = 6'h03;
  localparam logic [OP_W-1:0] OP_BRZ   = 6'h04;
  localparam logic [OP_W-1:0] OP_BRNZ  = 6'h05;
  localparam logic [OP_W-1:0] OP_TRAP  = 6'h11;
  localparam logic [OP_W-1:0] OP_RJMP  = 6'h12;
  localparam logic [OP_W-1:0] OP_RJMPL = 6'h13;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_JUMP   = 2'd1,
    SEL_BRANCH = 2'd2,
    SEL_REG    = 2'd3
  } tgtSel_e;

  typedef struct packed {
    tgtSel_e tgtSel;
    logic    linkEn;
    logic    badOp;
    logic    trapOp;
  } npcCtrl_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic            srcZero,
  input  logic            stepEn,
  output npcCtrl_t        ctrl
);

  logic seqOp;

  // Ordinary instructions: register ALU group, immediate group, memory group
  always_comb begin
    seqOp = 1'b0;
    if (opcode == 6'h00) seqOp = 1'b1;
    if (opcode[5:3] == 3'b001) seqOp = 1'b1;
    if (opcode[5:4] == 2'b10) seqOp = 1'b1;
  end

  always_comb begin
    ctrl        = '0;
    ctrl.tgtSel = SEL_SEQ;
    unique case (opcode)
      OP_JMP:    ctrl.tgtSel = SEL_JUMP;
      OP_JMPL: begin
        ctrl.tgtSel = SEL_JUMP;
        ctrl.linkEn = stepEn;
      end
      OP_BRZ:    ctrl.tgtSel = srcZero ? SEL_BRANCH : SEL_SEQ;
      OP_BRNZ:   ctrl.tgtSel = srcZero ? SEL_SEQ : SEL_BRANCH;
      OP_RJMP:   ctrl.tgtSel = SEL_REG;
      OP_RJMPL: begin
        ctrl.tgtSel = SEL_REG;
        ctrl.linkEn = stepEn;
      end
      OP_TRAP:   ctrl.trapOp = 1'b1;
      default:   ctrl.badOp  = !seqOp;
    endcase
  end

endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int JOFF_W    = 26,
  parameter int BOFF_W    = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stepEn,
  input  npcCtrl_t        ctrl,
  input  logic [JOFF_W-1:0] jumpOff,
  input  logic [BOFF_W-1:0] branchOff,
  input  logic [XLEN-1:0] srcVal,
  output logic            srcZero,
  output logic [XLEN-1:0] pcQ,
  output logic [XLEN-1:0] pcNext,
  output logic [XLEN-1:0] seqPc
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] jumpExt;
  logic [XLEN-1:0] branchExt;
  logic [XLEN-1:0] jumpTgt;
  logic [XLEN-1:0] branchTgt;

  assign srcZero   = (srcVal == '0);
  assign seqPc     = pcQ + STEP;
  assign jumpExt   = {{(XLEN-JOFF_W){jumpOff[JOFF_W-1]}}, jumpOff};
  assign branchExt = {{(XLEN-BOFF_W){branchOff[BOFF_W-1]}}, branchOff};
  assign jumpTgt   = seqPc + jumpExt;
  assign branchTgt = seqPc + branchExt;

  always_comb begin
    unique case (ctrl.tgtSel)
      SEL_JUMP:   pcNext = jumpTgt;
      SEL_BRANCH: pcNext = branchTgt;
      SEL_REG:    pcNext = srcVal;
      default:    pcNext = seqPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)       pcQ <= '0;
    else if (stepEn) pcQ <= pcNext;
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int JOFF_W = 26,
  parameter int BOFF_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stepEn,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] srcVal,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] nextPc,
  output logic            linkWe,
  output logic [XLEN-1:0] linkData,
  output logic            illegal,
  output logic            trapReq
);

  localparam int OP_LSB = 32 - OP_W;

  npcCtrl_t        ctrl;
  logic            srcZero;
  logic [XLEN-1:0] seqPc;

  npc_ctrl u_ctrl (
    .opcode  (instr[31:OP_LSB]),
    .srcZero (srcZero),
    .stepEn  (stepEn),
    .ctrl    (ctrl)
  );

  npc_datapath #(
    .XLEN   (XLEN),
    .JOFF_W (JOFF_W),
    .BOFF_W (BOFF_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stepEn    (stepEn),
    .ctrl      (ctrl),
    .jumpOff   (instr[JOFF_W-1:0]),
    .branchOff (instr[BOFF_W-1:0]),
    .srcVal    (srcVal),
    .srcZero   (srcZero),
    .pcQ       (pcOut),
    .pcNext    (nextPc),
    .seqPc     (seqPc)
  );

  assign linkWe   = ctrl.linkEn;
  assign linkData = seqPc;
  assign illegal  = ctrl.badOp;
  assign trapReq  = ctrl.trapOp;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            stepEn,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] srcVal,
  input logic [XLEN-1:0] pcOut,
  input logic [XLEN-1:0] nextPc,
  input logic            linkWe,
  input logic [XLEN-1:0] linkData,
  input logic            illegal,
  input logic            trapReq
);

  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepEn |=> pcOut == $past(nextPc));

  // R1
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stepEn |=> pcOut == $past(pcOut));

  // R4
  link_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> linkData == pcOut + 32'd4);

  // R10
  illegal_fallthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (nextPc == pcOut + 32'd4) && !linkWe);

  // R11
  link_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stepEn |-> !linkWe);

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({illegal, trapReq, linkWe}));

  // R5
  brz_nottaken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instr[31:26] == 6'h04 && srcVal != '0) |-> nextPc == pcOut + 32'd4);

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/npc_unit_test.sv
module npc_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepEn = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] pcOut, nextPc, linkData;
  logic        linkWe, illegal, trapReq;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  npc_unit uut (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .instr(instr), .srcVal(srcVal),
    .pcOut(pcOut), .nextPc(nextPc), .linkWe(linkWe), .linkData(linkData),
    .illegal(illegal), .trapReq(trapReq)
  );

  // instr, srcVal, expected nextPc, linkWe, linkData, illegal, trapReq
  localparam int NVEC = 15;
  localparam logic [130:0] VEC [NVEC] = '{
    {32'h0000_0000, 32'h0, 32'h0000_0004, 1'b0, 32'h0, 1'b0, 1'b0}, // R2 pc 0
    {32'h0800_0100, 32'h0, 32'h0000_0108, 1'b0, 32'h0, 1'b0, 1'b0}, // R3 pc 4
    {32'h1020_0010, 32'h0, 32'h0000_011C, 1'b0, 32'h0, 1'b0, 1'b0}, // R5 taken
    {32'h1020_0010, 32'h5, 32'h0000_0120, 1'b0, 32'h0, 1'b0, 1'b0}, // R5 not taken
    {32'h1420_FFF0, 32'h5, 32'h0000_0114, 1'b0, 32'h0, 1'b0, 1'b0}, // R6 taken back
    {32'h1420_FFF0, 32'h0, 32'h0000_0118, 1'b0, 32'h0, 1'b0, 1'b0}, // R6 not taken
    {32'h0FFF_FFE8, 32'h0, 32'h0000_0104, 1'b1, 32'h11C, 1'b0, 1'b0}, // R4 back
    {32'h4820_0000, 32'h4000, 32'h0000_4000, 1'b0, 32'h0, 1'b0, 1'b0}, // R7
    {32'h4C20_0000, 32'h8000_0000, 32'h8000_0000, 1'b1, 32'h4004, 1'b0, 1'b0}, // R8
    {32'hFC00_0000, 32'h0, 32'h8000_0004, 1'b0, 32'h0, 1'b1, 1'b0}, // R10
    {32'h4400_0000, 32'h0, 32'h8000_0008, 1'b0, 32'h0, 1'b0, 1'b1}, // R9
    {32'h2000_0000, 32'h0, 32'h8000_000C, 1'b0, 32'h0, 1'b0, 1'b0}, // R2 op 0x08
    {32'h8C00_0000, 32'h0, 32'h8000_0010, 1'b0, 32'h0, 1'b0, 1'b0}, // R2 op 0x23
    {32'h0A00_0000, 32'h0, 32'h7E00_0014, 1'b0, 32'h0, 1'b0, 1'b0}, // R12 jump min
    {32'h1020_8000, 32'h0, 32'h7DFF_8018, 1'b0, 32'h0, 1'b0, 1'b0}  // R12 branch min
  };

  function automatic string tagOf(input logic [31:0] w, input int idx);
    if (idx >= 13) return "R12";
    case (w[31:26])
      6'h02: return "R3";
      6'h03: return "R4";
      6'h04: return "R5";
      6'h05: return "R6";
      6'h12: return "R7";
      6'h13: return "R8";
      6'h11: return "R9";
      6'h3F: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1", "pc after reset", pcOut, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [130:0] v;
      v = VEC[i];
      instr  = v[130:99];
      srcVal = v[98:67];
      stepEn = 1'b1;
      #1;
      check(tagOf(v[130:99], i), "nextPc", nextPc, v[66:35]);
      check(tagOf(v[130:99], i), "linkWe", {31'b0, linkWe}, {31'b0, v[34]});
      if (v[34]) check(tagOf(v[130:99], i), "linkData", linkData, v[33:2]);
      check(tagOf(v[130:99], i), "illegal", {31'b0, illegal}, {31'b0, v[1]});
      check(tagOf(v[130:99], i), "trapReq", {31'b0, trapReq}, {31'b0, v[0]});
      @(posedge clk);
      @(negedge clk);
      // R1 step
      check("R1", "pc after step", pcOut, v[66:35]);
    end

    // R11 and R1 hold: linking jump with stepEn low
    instr  = 32'h0C00_0040;
    stepEn = 1'b0;
    #1;
    check("R11", "linkWe gated", {31'b0, linkWe}, 32'h0);
    check("R4", "target while held", nextPc, 32'h7DFF_805C);
    @(posedge clk);
    @(negedge clk);
    check("R1", "pc held", pcOut, 32'h7DFF_8018);

    // R12 wrap past the top of the address space
    instr  = 32'h4800_0000;
    srcVal = 32'hFFFF_FFFC;
    stepEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instr = 32'h0C00_0008;
    #1;
    check("R12", "wrapped link", linkData, 32'h0000_0000);
    check("R12", "wrapped target", nextPc, 32'h0000_0008);

    // R1 reset mid-run
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", "pc after second reset", pcOut, 32'h0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule